// File: doc/BRIEF.md
# Dual-Mode RAM Self-Test Analyser

This block tests a row of small embedded RAMs, each 32 words by 4 bits. A host drives the test over an 8-bit bus. One byte goes in per write, and a select code picks which stimulus register it fills: write address, read address, expected or write data, or control. After loading, the host pulses a step input. That pulse performs one RAM operation on every RAM at once and, on a read, compares the result. The march algorithm runs on the host. The block holds only the RAMs, the stimulus registers and one analyser per RAM.

The analyser has two modes, and the mode is captured while reset is held.

- **Single-port mode:** each RAM's one data port carries both reads and writes. The analyser drives write data onto that shared port through an enable taken from the active-low read enable. On a read it checks the returned word against the expected data register.
- **Dual-port mode:** the write drive is always on. Each RAM's read word is checked against the read word of the RAM below it, and the lowest RAM is checked against the expected data.

A mismatch sets a sticky flag. All flags form a shift chain that the host can unload at the end of a test.

Top module: `ram_bist_analyser`

## Requirements
- R1: While rst_ni is low, all flags clear to 0 and the stimulus registers reset to write address 0, read address 0, data 0, read enable inactive, write enable off and write mask all ones. A step pulse issued with these reset values changes no flag.
- R2: On a clock edge with host_wr_i high, host_sel_i selects the register loaded from host_data_i: 0 loads the write address from bits 4:0, 1 loads the read address from bits 4:0, 2 loads the data from bits 3:0, 3 loads the control. The control fields are bit 0 for the active-low read enable, bit 1 for write enable, and bits 7:4 for the write mask, where bit 4+i enables RAM i.
- R3: In single-port mode, a step with read enable inactive (1) and write enable 1 writes the data register into every masked RAM at the write address.
- R4: In single-port mode, a step with read enable active (0) reads every RAM at the write address and sets the flag of each RAM whose word differs from the data register. No write happens in that step, even with write enable 1.
- R5: In dual-port mode, a step with write enable 1 writes at the write address whatever the read enable is. A step with read enable 0 reads at the read address. RAM i (i>0) flags when its word differs from the word of RAM i-1, and RAM 0 flags when its word differs from the data register.
- R6: A set flag stays set through idle cycles and through later matching reads, until reset or a scan shift.
- R7: With scan_en_i high, each edge shifts the flags one place toward the higher index: flag 0 takes scan_in_i and scan_out_o shows the top flag. While scanning, compares do not update the flags.
- R8: dual_mode_i is sampled only while rst_ni is low (1 selects dual-port mode). Changes to it after reset has been released have no effect.
- R9: A RAM whose write-mask bit is 0 is not written by a step, so its neighbours and the data register can be made to disagree with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; mode capture while low |
| host_data_i | input | 8 | Host stimulus byte |
| host_sel_i | input | 2 | Stimulus register select |
| host_wr_i | input | 1 | Load strobe for the selected register |
| step_i | input | 1 | Host-issued test step |
| dual_mode_i | input | 1 | Mode request, 1 = dual-port |
| scan_en_i | input | 1 | Flag chain shift enable |
| scan_in_i | input | 1 | Serial input to flag 0 |
| scan_out_o | output | 1 | Serial output from the top flag |
| flags_o | output | NUM_RAMS | Current analyser flags |

## Verification
The bench targets the following corner cases.

- **Read with write enable on in single-port mode.** A design that still writes would overwrite the RAM, so the later matching read would flag.
- **Masked write followed by a dual-port read.** This makes one RAM disagree with both of its neighbours. A wrong neighbour index or a wrong reference for RAM 0 gives the wrong flag pattern.
- **Write with read enable active in dual-port mode.** This write must land. A design that gates the write drive as it does in single-port mode leaves the address unwritten.
- **Scan shift together with a mismatching step.** Only the shifted pattern may appear. Toggling the mode input after reset must not change which address the RAMs read.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int HOST_W = 8;
  localparam int MASK_W = 4;

  typedef enum logic [1:0] {
    SEL_WADDR = 2'd0,
    SEL_RADDR = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              we;
    logic              rd_n;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{mask: '1, we: 1'b0, rd_n: 1'b1};
endpackage

// File: rtl/bist_stim_regs.sv
module bist_stim_regs
  import bist_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOST_W-1:0] host_data_i,
  input  logic [1:0]        host_sel_i,
  input  logic              host_wr_i,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] data_o,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_o <= '0;
      raddr_o <= '0;
      data_o  <= '0;
      ctrl_o  <= CTRL_RST;
    end else if (host_wr_i) begin
      unique case (sel_e'(host_sel_i))
        SEL_WADDR: waddr_o <= host_data_i[ADDR_W-1:0];
        SEL_RADDR: raddr_o <= host_data_i[ADDR_W-1:0];
        SEL_DATA:  data_o  <= host_data_i[DATA_W-1:0];
        SEL_CTRL:  ctrl_o  <= '{mask: host_data_i[HOST_W-1 -: MASK_W],
                                we: host_data_i[1], rd_n: host_data_i[0]};
        default: ;
      endcase
    end
  end

  a_r2_waddr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_sel_i == 2'd0 |=> waddr_o == $past(host_data_i[ADDR_W-1:0]));
  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_sel_i == 2'd3 |=> ctrl_o.rd_n == $past(host_data_i[0]));
endmodule

// File: rtl/bist_ram_model.sv
module bist_ram_model #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= d_i;
  end

  assign q_o = mem[raddr_i];
endmodule

// File: rtl/bist_analyser.sv
module bist_analyser #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_i,
  input  logic              step_i,
  input  logic              scan_en_i,
  input  logic              scan_in_i,
  input  logic              rd_n_i,
  input  logic              we_i,
  input  logic              wsel_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] nbr_i,
  input  logic [DATA_W-1:0] q_i,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_d_o,
  output logic              flag_o
);
  logic              drive_en;
  logic              rd_act;
  logic              miss;
  logic [DATA_W-1:0] port_d;
  logic [DATA_W-1:0] obs_d;
  logic [DATA_W-1:0] ref_d;

  // shared port: write drive enabled by inactive read, or always in dual mode
  assign drive_en = dual_i | rd_n_i;
  assign port_d   = drive_en ? exp_i : q_i;
  assign ram_d_o  = port_d;
  assign ram_we_o = step_i & we_i & wsel_i & drive_en;

  assign rd_act = step_i & ~rd_n_i;
  assign obs_d  = dual_i ? q_i : port_d;
  assign ref_d  = dual_i ? nbr_i : exp_i;
  assign miss   = rd_act & (obs_d != ref_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_o <= 1'b0;
    else if (scan_en_i) flag_o <= scan_in_i;
    else if (miss)      flag_o <= 1'b1;
  end

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !scan_en_i |=> flag_o);
  a_r7_scan_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> flag_o == $past(scan_in_i));
  a_r4_single_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i && step_i && !rd_n_i && !scan_en_i && q_i != exp_i |=> flag_o);
  a_r4_no_write_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i && !rd_n_i |-> !ram_we_o);
  a_r5_dual_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i && step_i && !rd_n_i && !scan_en_i && q_i != nbr_i |=> flag_o);
endmodule

// File: rtl/ram_bist_analyser.sv
module ram_bist_analyser
  import bist_pkg::*;
#(
  parameter int NUM_RAMS = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HOST_W-1:0]   host_data_i,
  input  logic [1:0]          host_sel_i,
  input  logic                host_wr_i,
  input  logic                step_i,
  input  logic                dual_mode_i,
  input  logic                scan_en_i,
  input  logic                scan_in_i,
  output logic                scan_out_o,
  output logic [NUM_RAMS-1:0] flags_o
);
  logic [ADDR_W-1:0] waddr, raddr, rd_addr;
  logic [DATA_W-1:0] data;
  ctrl_t             ctrl;
  logic              mode_q;

  logic [DATA_W-1:0] q    [NUM_RAMS];
  logic [DATA_W-1:0] d    [NUM_RAMS];
  logic [DATA_W-1:0] nbr  [NUM_RAMS];
  logic [NUM_RAMS-1:0] ram_we;
  logic [NUM_RAMS-1:0] chain_in;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= dual_mode_i;
  end

  bist_stim_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stim (
    .clk_i, .rst_ni, .host_data_i, .host_sel_i, .host_wr_i,
    .waddr_o(waddr), .raddr_o(raddr), .data_o(data), .ctrl_o(ctrl)
  );

  assign rd_addr    = mode_q ? raddr : waddr;
  assign scan_out_o = flags_o[NUM_RAMS-1];

  for (genvar i = 0; i < NUM_RAMS; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign nbr[i]      = data;
      assign chain_in[i] = scan_in_i;
    end else begin : g_rest
      assign nbr[i]      = q[i-1];
      assign chain_in[i] = flags_o[i-1];
    end

    bist_ram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk_i, .we_i(ram_we[i]), .waddr_i(waddr), .d_i(d[i]),
      .raddr_i(rd_addr), .q_o(q[i])
    );

    bist_analyser #(.DATA_W(DATA_W)) u_ana (
      .clk_i, .rst_ni, .dual_i(mode_q), .step_i, .scan_en_i,
      .scan_in_i(chain_in[i]), .rd_n_i(ctrl.rd_n), .we_i(ctrl.we),
      .wsel_i(ctrl.mask[i]), .exp_i(data), .nbr_i(nbr[i]), .q_i(q[i]),
      .ram_we_o(ram_we[i]), .ram_d_o(d[i]), .flag_o(flags_o[i])
    );
  end

  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));
  a_r7_scan_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> scan_out_o == $past(flags_o[NUM_RAMS-2]));
endmodule

// File: tb/ram_bist_analyser_tb.sv
module ram_bist_analyser_tb;
  localparam int N = 4;
  localparam time HALF = 2.5ns;

  logic clk = 0, rst_ni = 0;
  logic [7:0] host_data = 0;
  logic [1:0] host_sel = 0;
  logic host_wr = 0, step = 0, dual = 0, scan_en = 0, scan_in = 0;
  logic scan_out;
  logic [N-1:0] flags;
  int tests = 0, fails = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  ram_bist_analyser u_dut (
    .clk_i(clk), .rst_ni, .host_data_i(host_data), .host_sel_i(host_sel),
    .host_wr_i(host_wr), .step_i(step), .dual_mode_i(dual),
    .scan_en_i(scan_en), .scan_in_i(scan_in), .scan_out_o(scan_out),
    .flags_o(flags)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk); rst_ni = 0; dual = mode;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic load(logic [1:0] sel, logic [7:0] b);
    @(negedge clk); host_wr = 1; host_sel = sel; host_data = b;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic pulse(logic scan, logic sin);
    @(negedge clk); step = 1; scan_en = scan; scan_in = sin;
    @(negedge clk); step = 0; scan_en = 0; scan_in = 0;
  endtask

  task automatic t_reset;
    do_reset(0);
    chk("R1 flags", flags, '0);
    chk("R1 scan_out", {3'b0, scan_out}, '0);
    pulse(0, 0);
    chk("R1 default ctrl step", flags, '0);
  endtask

  task automatic t_single_rw;
    load(0, 8'd5); load(2, 8'hA); load(3, 8'hF3);
    pulse(0, 0);
    load(3, 8'hF0); pulse(0, 0);
    chk("R3 write then matching read", flags, 4'b0000);
    load(2, 8'h3); pulse(0, 0);
    chk("R4 mismatching read", flags, 4'b1111);
  endtask

  task automatic t_no_write_on_read;
    do_reset(0);
    load(0, 8'd5); load(2, 8'h3); load(3, 8'hF2);
    pulse(0, 0);
    chk("R4 read with we set flags", flags, 4'b1111);
    do_reset(0);
    load(0, 8'd5); load(2, 8'hA); load(3, 8'hF0);
    pulse(0, 0);
    chk("R4 data kept after read with we", flags, 4'b0000);
  endtask

  task automatic t_mask_sticky;
    do_reset(0);
    load(0, 8'd9); load(2, 8'h0); load(3, 8'hF3); pulse(0, 0);
    load(2, 8'h5); load(3, 8'h23); pulse(0, 0);
    load(2, 8'h0); load(3, 8'hF0); pulse(0, 0);
    chk("R9 masked write", flags, 4'b0010);
    repeat (3) @(negedge clk);
    chk("R6 idle hold", flags, 4'b0010);
    load(0, 8'd5); load(2, 8'hA); pulse(0, 0);
    chk("R6 hold on matching read", flags, 4'b0010);
  endtask

  task automatic t_scan;
    @(negedge clk); scan_en = 1; scan_in = 1;
    @(negedge clk); scan_en = 0; scan_in = 0;
    chk("R7 shift one", flags, 4'b0101);
    chk("R7 scan_out low", {3'b0, scan_out}, 4'b0000);
    @(negedge clk); scan_en = 1;
    @(negedge clk); scan_en = 0;
    chk("R7 shift two", flags, 4'b1010);
    chk("R7 scan_out high", {3'b0, scan_out}, 4'b0001);
    load(2, 8'h3);
    pulse(1, 0);
    chk("R7 scan over compare", flags, 4'b0100);
  endtask

  task automatic t_dual;
    do_reset(1);
    load(1, 8'd9); load(2, 8'h0); load(3, 8'hF0);
    pulse(0, 0);
    chk("R5 neighbour compare", flags, 4'b0110);
    do_reset(1);
    load(0, 8'd12); load(1, 8'd5); load(2, 8'h7); load(3, 8'hF2);
    pulse(0, 0);
    chk("R5 ram0 vs data", flags, 4'b0001);
    do_reset(1);
    load(1, 8'd12); load(2, 8'h7); load(3, 8'hF0);
    pulse(0, 0);
    chk("R5 write with read active", flags, 4'b0000);
  endtask

  task automatic t_mode_hold;
    do_reset(1);
    @(negedge clk); dual = 0;
    load(0, 8'd5); load(1, 8'd9); load(2, 8'hA); load(3, 8'hF0);
    pulse(0, 0);
    chk("R8 mode held after reset", flags, 4'b0111);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_rw();
    t_no_write_on_read();
    t_mask_sticky();
    t_scan();
    t_dual();
    t_mode_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule